// File: doc/BRIEF.md
# Program/Erase Status Reporting Unit

This unit sits beside the command decoder of a byte-wide nonvolatile memory. When the decoder accepts a byte-program or whole-array erase command, it pulses a start strobe. With that strobe it passes the target address, the operation kind and bit 7 of the byte being written. The unit then times the operation internally. Both durations are parameters counted in clock cycles. While the timer runs, the unit reports progress in three ways at once.

The first is a countdown value that can be observed. The second is a pulldown enable for a shared, wire-ORed ready/busy line. The third is an overlay on read data. A read of the address being programmed returns the complement of the loaded bit 7. Every read strobe flips bit 6, whatever the operation. Once the timer expires, reads return the array contents unchanged.

The read strobe is a single-cycle pulse. It marks one host read access, that is, one falling edge of output enable or chip enable, as detected upstream. A synchronous active-high reset aborts an operation that is in progress.

Top module: `pe_status_unit`

## Requirements
- R1: After reset, busy_o and rb_pull_o are 0, busy_cnt_o is 0, and rd_data_o equals array_data_i.
- R2: A start with erase_i=0, accepted while idle, makes busy_cnt_o equal PROG_CYCLES in the next cycle. The count then falls by one per cycle, and busy_o stays high for exactly PROG_CYCLES cycles.
- R3: A start with erase_i=1, accepted while idle, behaves the same way with ERASE_CYCLES.
- R4: rb_pull_o (1 = pull the shared ready/busy line low, 0 = release it) is 1 exactly in the cycles where busy_o is 1.
- R5: During a program, a read at the latched address returns on bit 7 the complement of load_poll_bit_i as captured at the start. Bits 5..0 come from array_data_i.
- R6: During a program, reads at any other address return bit 7 from array_data_i. During an erase, every read does the same.
- R7: While busy, bit 6 of each strobed read is the inverse of bit 6 of the previous strobed read in the same operation. Cycles without a strobe leave it unchanged.
- R8: While idle, rd_data_o equals array_data_i on all eight bits. This holds in the very cycle in which a start is accepted.
- R9: A start arriving while busy is ignored, including in the last busy cycle. The count is not reloaded, the latched address and bit are kept, and no second operation follows.
- R10: rst=1 while busy ends the operation at the next edge. The count goes to 0, busy_o and rb_pull_o go to 0, and reads pass through unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running operation |
| start_i | input | 1 | One-cycle command-accepted strobe from the decoder |
| erase_i | input | 1 | Operation kind with start_i: 0 program, 1 erase |
| load_addr_i | input | AW | Address of the byte being programmed |
| load_poll_bit_i | input | 1 | Bit 7 of the byte being programmed |
| rd_stb_i | input | 1 | One-cycle pulse per host read access |
| rd_addr_i | input | AW | Address of the current read |
| array_data_i | input | 8 | Byte read from the storage array |
| rd_data_o | output | 8 | Read data with status overlay applied |
| busy_o | output | 1 | Operation in progress |
| busy_cnt_o | output | CW | Remaining cycles of the running operation |
| rb_pull_o | output | 1 | Pulldown enable for the open-drain ready/busy line |

## Verification
Two events can coincide with the completion of an operation. One is a read strobe in the final busy cycle, when the count is 1. The other is a new start strobe in that same cycle. The bench issues a read on the last busy cycle and expects the polled and toggled value, then expects the true array byte on the read one cycle later. It also places an erase start exactly on the last cycle of a program and expects the line to go idle on the next cycle, with a count of zero. A third case, a start and a read in the same idle cycle, must return unmodified array data.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

    localparam int DW       = 8;
    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     poll_ref;
    } op_ctx_t;

    function automatic int cnt_bits(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer
    import pe_status_pkg::*;
#(
    parameter int AW           = 20,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 500000,
    parameter int CW           = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  op_kind_e      kind_i,
    input  logic          poll_bit_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output op_ctx_t       ctx_o,
    output logic [AW-1:0] addr_o
);

    localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYCLES);
    localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYCLES);

    logic [CW-1:0] cnt_q;
    op_ctx_t       ctx_q;
    logic [AW-1:0] addr_q;
    logic          idle;
    logic          accept;

    assign idle   = (cnt_q == '0);
    assign accept = start_i && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ctx_q  <= '{kind: OP_PROG, poll_ref: 1'b0};
            addr_q <= '0;
        end else if (accept) begin
            cnt_q  <= (kind_i == OP_ERASE) ? ERASE_LD : PROG_LD;
            ctx_q  <= '{kind: kind_i, poll_ref: poll_bit_i};
            addr_q <= addr_i;
        end else if (!idle) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = !idle;
    assign cnt_o  = cnt_q;
    assign ctx_o  = ctx_q;
    assign addr_o = addr_q;

endmodule

// File: rtl/pe_toggle_gen.sv
module pe_toggle_gen (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic rd_stb_i,
    output logic tgl_o
);

    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q <= 1'b0;
        end else if (busy_i && rd_stb_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign tgl_o = tgl_q;

endmodule

// File: rtl/pe_read_overlay.sv
module pe_read_overlay
    import pe_status_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          busy_i,
    input  op_ctx_t       ctx_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic          tgl_i,
    input  logic [DW-1:0] array_i,
    output logic [DW-1:0] data_o
);

    logic poll_hit;

    assign poll_hit = busy_i && (ctx_i.kind == OP_PROG) && (rd_addr_i == op_addr_i);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign data_o[b] = poll_hit ? ~ctx_i.poll_ref : array_i[b];
        end else if (b == TGL_BIT) begin : g_tgl
            assign data_o[b] = busy_i ? tgl_i : array_i[b];
        end else begin : g_pass
            assign data_o[b] = array_i[b];
        end
    end

endmodule

// File: rtl/pe_status_unit.sv
module pe_status_unit
    import pe_status_pkg::*;
#(
    parameter int  AW           = 20,
    parameter int  PROG_CYCLES  = 500,
    parameter int  ERASE_CYCLES = 500000,
    localparam int CW           = cnt_bits(PROG_CYCLES, ERASE_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          load_poll_bit_i,
    input  logic          rd_stb_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] array_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o,
    output logic [CW-1:0] busy_cnt_o,
    output logic          rb_pull_o
);

    logic          busy;
    op_ctx_t       ctx;
    logic [AW-1:0] op_addr;
    logic          tgl;
    op_kind_e      kind_in;

    assign kind_in = erase_i ? OP_ERASE : OP_PROG;

    pe_op_timer #(
        .AW          (AW),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .CW          (CW)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .kind_i    (kind_in),
        .poll_bit_i(load_poll_bit_i),
        .addr_i    (load_addr_i),
        .busy_o    (busy),
        .cnt_o     (busy_cnt_o),
        .ctx_o     (ctx),
        .addr_o    (op_addr)
    );

    pe_toggle_gen u_toggle (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy),
        .rd_stb_i(rd_stb_i),
        .tgl_o   (tgl)
    );

    pe_read_overlay #(
        .AW(AW)
    ) u_overlay (
        .busy_i   (busy),
        .ctx_i    (ctx),
        .op_addr_i(op_addr),
        .rd_addr_i(rd_addr_i),
        .tgl_i    (tgl),
        .array_i  (array_data_i),
        .data_o   (rd_data_o)
    );

    assign busy_o    = busy;
    assign rb_pull_o = busy;

endmodule

// File: rtl/pe_status_checker.sv
module pe_status_checker #(
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 500000,
    parameter int CW           = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          erase_i,
    input logic [7:0]    array_data_i,
    input logic [7:0]    rd_data_o,
    input logic          busy_o,
    input logic [CW-1:0] busy_cnt_o,
    input logic          rb_pull_o
);

    AST_PROG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !erase_i) |=> (busy_cnt_o == CW'(PROG_CYCLES))); // R2

    AST_ERASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && erase_i) |=> (busy_cnt_o == CW'(ERASE_CYCLES))); // R3

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_cnt_o == CW'($past(busy_cnt_o) - 1'b1))); // R9

    AST_LINE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        rb_pull_o == (busy_cnt_o != '0)); // R4

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (rd_data_o == array_data_i)); // R8

    AST_RESET_ABORT: assert property (@(posedge clk)
        rst |=> (!busy_o && !rb_pull_o && busy_cnt_o == '0)); // R10

endmodule

bind pe_status_unit pe_status_checker #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .CW          (CW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .erase_i     (erase_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o),
    .busy_o      (busy_o),
    .busy_cnt_o  (busy_cnt_o),
    .rb_pull_o   (rb_pull_o)
);

// File: tb/pe_status_unit_tb.sv
module pe_status_unit_tb;

    localparam int AW    = 8;
    localparam int PROG  = 10;
    localparam int ERASE = 24;
    localparam int CW    = $clog2(ERASE + 1);

    localparam logic [1:0] K_NOP = 2'd0, K_PROG = 2'd1, K_ERASE = 2'd2, K_RD = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] addr;
        logic [7:0] val;
        logic [7:0] exp;
        logic [1:0] b6;    // 0 exact, 1 must invert, 2 first read: record
        logic       ebusy;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{K_RD,    8'h10, 8'h5A, 8'h5A, 2'd0, 1'b0, 4'd8},  // R8 idle read
        '{K_PROG,  8'h33, 8'hC3, 8'h00, 2'd0, 1'b0, 4'd2},  // R2 start program
        '{K_RD,    8'h33, 8'hFF, 8'h3F, 2'd2, 1'b1, 4'd5},  // R5 poll bit inverted
        '{K_RD,    8'h33, 8'hFF, 8'h3F, 2'd1, 1'b1, 4'd7},  // R7 toggle
        '{K_RD,    8'h34, 8'hA5, 8'hA5, 2'd1, 1'b1, 4'd6},  // R6 other address
        '{K_NOP,   8'h00, 8'h00, 8'h00, 2'd0, 1'b1, 4'd7},  // R7 no strobe
        '{K_ERASE, 8'h55, 8'h00, 8'h00, 2'd0, 1'b1, 4'd9},  // R9 ignored start
        '{K_RD,    8'h33, 8'hFF, 8'h3F, 2'd1, 1'b1, 4'd9},  // R9 bit kept
        '{K_RD,    8'h55, 8'hFF, 8'hBF, 2'd1, 1'b1, 4'd9},  // R9 address kept
        '{K_NOP,   8'h00, 8'h00, 8'h00, 2'd0, 1'b1, 4'd4},  // R4
        '{K_NOP,   8'h00, 8'h00, 8'h00, 2'd0, 1'b1, 4'd4},  // R4
        '{K_RD,    8'h33, 8'hFF, 8'h3F, 2'd1, 1'b1, 4'd5},  // R5 last busy cycle
        '{K_RD,    8'h33, 8'hFF, 8'hFF, 2'd0, 1'b0, 4'd8},  // R8 done
        '{K_RD,    8'h33, 8'hC3, 8'hC3, 2'd0, 1'b0, 4'd8}   // R8
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          erase_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          load_poll_bit_i = 1'b0;
    logic          rd_stb_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [7:0]    array_data_i = '0;
    logic [7:0]    rd_data_o;
    logic          busy_o;
    logic [CW-1:0] busy_cnt_o;
    logic          rb_pull_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic prev_b6 = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    pe_status_unit #(
        .AW          (AW),
        .PROG_CYCLES (PROG),
        .ERASE_CYCLES(ERASE)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .erase_i        (erase_i),
        .load_addr_i    (load_addr_i),
        .load_poll_bit_i(load_poll_bit_i),
        .rd_stb_i       (rd_stb_i),
        .rd_addr_i      (rd_addr_i),
        .array_data_i   (array_data_i),
        .rd_data_o      (rd_data_o),
        .busy_o         (busy_o),
        .busy_cnt_o     (busy_cnt_o),
        .rb_pull_o      (rb_pull_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_b6(input string req, input logic [1:0] mode, input logic got);
        if (mode == 2'd2) begin
            prev_b6 = got;
        end else if (mode == 2'd1) begin
            chk(req, {31'd0, got}, {31'd0, ~prev_b6});
            prev_b6 = got;
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        start_i         = (k == K_PROG) || (k == K_ERASE);
        erase_i         = (k == K_ERASE);
        load_addr_i     = a;
        rd_addr_i       = a;
        load_poll_bit_i = v[7];
        rd_stb_i        = (k == K_RD);
        array_data_i    = v;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        array_data_i = 8'h6C;
        #1;
        chk("R1 busy", {31'd0, busy_o}, 0);
        chk("R1 cnt", 32'(busy_cnt_o), 0);
        chk("R1 line", {31'd0, rb_pull_o}, 0);
        chk("R1 data", {24'd0, rd_data_o}, 32'h6C);

        // vector table
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].kind, VEC[i].addr, VEC[i].val);
            chk($sformatf("R%0d row %0d busy", VEC[i].req, i), {31'd0, busy_o}, {31'd0, VEC[i].ebusy});
            chk($sformatf("R4 row %0d line", i), {31'd0, rb_pull_o}, {31'd0, VEC[i].ebusy});
            if (VEC[i].kind == K_RD) begin
                if (VEC[i].b6 == 2'd0)
                    chk($sformatf("R%0d row %0d data", VEC[i].req, i), {24'd0, rd_data_o}, {24'd0, VEC[i].exp});
                else begin
                    chk($sformatf("R%0d row %0d data", VEC[i].req, i),
                        {24'd0, rd_data_o & 8'hBF}, {24'd0, VEC[i].exp & 8'hBF});
                    chk_b6($sformatf("R7 row %0d bit6", i), VEC[i].b6, rd_data_o[6]);
                end
            end
        end

        // R2 program count, R5 with loaded bit 7 = 0
        step(K_PROG, 8'h01, 8'h00);
        step(K_RD, 8'h01, 8'h00);
        chk("R2 load", 32'(busy_cnt_o), PROG);
        chk("R5 poll zero", {24'd0, rd_data_o & 8'hBF}, 32'h80);
        for (int k = 2; k <= 9; k++) begin
            step(K_NOP, 8'h00, 8'h00);
            chk("R2 count", 32'(busy_cnt_o), 32'(PROG + 1 - k));
        end
        // R9 start on the last busy cycle
        step(K_ERASE, 8'h02, 8'h00);
        chk("R9 last busy", {31'd0, busy_o}, 1);
        chk("R2 last count", 32'(busy_cnt_o), 1);
        step(K_NOP, 8'h00, 8'h00);
        chk("R9 no second op", {31'd0, busy_o}, 0);
        chk("R2 end count", 32'(busy_cnt_o), 0);

        // R3 erase timing, R6 no poll during erase, R7 toggle during erase
        step(K_ERASE, 8'h20, 8'h00);
        step(K_RD, 8'h01, 8'h80);
        chk("R3 load", 32'(busy_cnt_o), ERASE);
        chk("R6 erase bit7", {24'd0, rd_data_o & 8'hBF}, 32'h80);
        chk_b6("R7 erase first", 2'd2, rd_data_o[6]);
        step(K_RD, 8'h20, 8'h00);
        chk("R6 erase same addr", {24'd0, rd_data_o & 8'hBF}, 32'h00);
        chk_b6("R7 erase toggle", 2'd1, rd_data_o[6]);
        for (int k = 3; k <= ERASE; k++) begin
            step(K_NOP, 8'h00, 8'h00);
            if (k == ERASE) chk("R3 count end", 32'(busy_cnt_o), 1);
        end
        chk("R3 still busy", {31'd0, busy_o}, 1);
        step(K_RD, 8'h01, 8'h80);
        chk("R3 done", {31'd0, busy_o}, 0);
        chk("R8 after erase", {24'd0, rd_data_o}, 32'h80);

        // R10 reset aborts a program
        step(K_PROG, 8'h44, 8'h80);
        repeat (3) step(K_NOP, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        step(K_RD, 8'h44, 8'h80);
        rst = 1'b0;
        #1;
        chk("R10 busy", {31'd0, busy_o}, 0);
        chk("R10 cnt", 32'(busy_cnt_o), 0);
        chk("R10 line", {31'd0, rb_pull_o}, 0);
        chk("R10 data", {24'd0, rd_data_o}, 32'h80);

        // R8 start and read in the same idle cycle
        @(negedge clk);
        start_i = 1'b1; erase_i = 1'b0; load_addr_i = 8'h66; load_poll_bit_i = 1'b1;
        rd_stb_i = 1'b1; rd_addr_i = 8'h66; array_data_i = 8'hF0;
        #1;
        chk("R8 start cycle data", {24'd0, rd_data_o}, 32'hF0);
        chk("R8 start cycle busy", {31'd0, busy_o}, 0);
        step(K_RD, 8'h66, 8'hF0);
        chk("R5 poll one", {24'd0, rd_data_o & 8'hBF}, 32'h30);
        repeat (PROG) step(K_NOP, 8'h00, 8'h00);
        chk("R2 idle again", {31'd0, busy_o}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule